// File: doc/BRIEF.md
# On-Chip Memory Map and Parallel Port Block

This block sits between a small 8-bit CPU core and its on-chip storage and I/O. It takes the core's 16-bit byte address, an 8-bit write byte and a write strobe. It steers each access to one of five targets: a 512-byte scratch RAM, a 12 KB program ROM, an output-only port, a bidirectional port's data latch, or that port's direction register. Read data is combinational, so the core sees the addressed byte in the same cycle it presents the address. Writes land on the rising clock edge.

The bidirectional port is modelled as three separate vectors: pin levels coming in, latch values going out, and a per-bit output enable. A direction bit of 1 turns that pin into an output. When the core reads the port, each bit shows the latch if the pin is an output, and the live pin level if it is an input.

The ROM has no storage array. Its image is a closed-form fill pattern set by the `ROM_KEY` parameter. The byte at offset `o` from the ROM base is `o[7:0] ^ (3*o[13:8]) ^ ROM_KEY`. This keeps elaboration small and gives a test bench a value it can predict for every ROM address.

Top module: `mcu_memmap`

## Requirements
- R1: Addresses 16'h0000..16'h01FF are a read-write RAM. A write with `cpu_we`=1 is stored on the rising edge. A read returns the stored byte combinationally in the same cycle.
- R2: The RAM does not alias. A write to 16'h0200 or above, below the ROM, leaves every RAM byte unchanged, and a read there returns 8'h00.
- R3: Addresses 16'hD000..16'hFFFF read the ROM pattern `o[7:0] ^ (3*o[13:8]) ^ ROM_KEY`, where `o` = address - 16'hD000 and `ROM_KEY` defaults to 8'hA5. Writes to this range change nothing.
- R4: 16'h1004 is the output-only port register. It resets to 8'h00. A write loads it and drives `portb_out`, and a read returns the latched value.
- R5: 16'h1007 is the direction register. It resets to 8'h00 (all bidirectional pins are inputs) and is readable. Bit i = 1 sets `portc_oe[i]`.
- R6: 16'h1003 writes the bidirectional port's output latch. The latch resets to 8'h00 and drives `portc_out` whatever the direction bits are.
- R7: A read of 16'h1003 returns, for each bit i, the latch bit when direction bit i is 1 and `portc_pin_in[i]` when it is 0.
- R8: Every other address (for example 16'h1000, 16'h1005, 16'h1006, 16'h1008, 16'hCFFF) reads 8'h00, and writes to it change no register.
- R9: With `cpu_we`=0 no RAM byte and no port or direction register changes, whatever `cpu_addr` and `cpu_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the port and direction registers |
| cpu_addr | input | 16 | Byte address from the core |
| cpu_wdata | input | 8 | Byte to write |
| cpu_we | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| portb_out | output | 8 | Output-only port levels |
| portc_pin_in | input | 8 | Pin levels seen on the bidirectional port |
| portc_out | output | 8 | Bidirectional port output latch |
| portc_oe | output | 8 | Per-bit output enable of the bidirectional port |

## Verification
The assertions assume three things about the inputs:
- `cpu_addr`, `cpu_we` and `cpu_wdata` are settled before each rising edge.
- The pin inputs may change at any time.
- Reads of RAM bytes that were never written are not checked for content.

The stimulus changes inputs only on falling edges. It writes each RAM location before reading it. It drives the pins to patterns that differ from the output latch, so that a read of the bidirectional port that picks the wrong source shows up.

// File: rtl/mcu_map_pkg.sv
package mcu_map_pkg;

  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_RAM   = 3'd1,
    RG_ROM   = 3'd2,
    RG_PORTB = 3'd3,
    RG_PORTC = 3'd4,
    RG_DDRC  = 3'd5
  } region_e;

  // Closed-form ROM fill: low offset byte, xor three times the high part, xor key.
  function automatic logic [7:0] rom_pattern(input logic [13:0] off, input logic [7:0] key);
    logic [7:0] hi;
    hi = {2'b00, off[13:8]} * 8'd3;
    return off[7:0] ^ hi ^ key;
  endfunction

  // Bidirectional port readback: latch where driven, pin where sensing.
  function automatic logic [7:0] portc_view(input logic [7:0] latch,
                                            input logic [7:0] pins,
                                            input logic [7:0] dir);
    return (latch & dir) | (pins & ~dir);
  endfunction

endpackage

// File: rtl/mcu_addr_decode.sv
module mcu_addr_decode
  import mcu_map_pkg::*;
#(
  parameter int AW         = 16,
  parameter int RAM_BASE   = 16'h0000,
  parameter int RAM_BYTES  = 512,
  parameter int ROM_BASE   = 16'hD000,
  parameter int ROM_BYTES  = 12288,
  parameter int PORTB_ADDR = 16'h1004,
  parameter int PORTC_ADDR = 16'h1003,
  parameter int DDRC_ADDR  = 16'h1007,
  localparam int RAM_IW    = $clog2(RAM_BYTES),
  localparam int ROM_IW    = $clog2(ROM_BYTES)
) (
  input  logic [AW-1:0]     addr,
  output region_e           region,
  output logic              sel_ram,
  output logic              sel_rom,
  output logic              sel_portb,
  output logic              sel_portc,
  output logic              sel_ddrc,
  output logic [RAM_IW-1:0] ram_idx,
  output logic [ROM_IW-1:0] rom_off
);
  localparam logic [AW:0] RAM_LO = (AW+1)'(RAM_BASE);
  localparam logic [AW:0] RAM_HI = (AW+1)'(RAM_BASE + RAM_BYTES);
  localparam logic [AW:0] ROM_LO = (AW+1)'(ROM_BASE);
  localparam logic [AW:0] ROM_HI = (AW+1)'(ROM_BASE + ROM_BYTES);

  logic [AW:0] a_ext;
  logic [AW:0] ram_rel;
  logic [AW:0] rom_rel;

  always_comb begin
    a_ext     = {1'b0, addr};
    ram_rel   = a_ext - RAM_LO;
    rom_rel   = a_ext - ROM_LO;
    sel_ram   = (a_ext >= RAM_LO) && (a_ext < RAM_HI);
    sel_rom   = (a_ext >= ROM_LO) && (a_ext < ROM_HI);
    sel_portb = (addr == AW'(PORTB_ADDR));
    sel_portc = (addr == AW'(PORTC_ADDR));
    sel_ddrc  = (addr == AW'(DDRC_ADDR));
    ram_idx   = ram_rel[RAM_IW-1:0];
    rom_off   = rom_rel[ROM_IW-1:0];
    if (sel_ram)        region = RG_RAM;
    else if (sel_rom)   region = RG_ROM;
    else if (sel_portb) region = RG_PORTB;
    else if (sel_portc) region = RG_PORTC;
    else if (sel_ddrc)  region = RG_DDRC;
    else                region = RG_NONE;
  end

endmodule

// File: rtl/mcu_ram.sv
module mcu_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

  // R1: a strobed write is visible at its address in the next cycle
  a_r1_ram_store: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/mcu_rom.sv
module mcu_rom
  import mcu_map_pkg::*;
#(
  parameter logic [7:0] ROM_KEY = 8'hA5,
  parameter int         OW      = 14
) (
  input  logic [OW-1:0] off,
  output logic [7:0]    rdata
);
  logic [13:0] off_w;

  generate
    if (OW >= 14) begin : g_trim
      assign off_w = off[13:0];
    end else begin : g_pad
      assign off_w = {{(14-OW){1'b0}}, off};
    end
  endgenerate

  assign rdata = rom_pattern(off_w, ROM_KEY);

endmodule

// File: rtl/mcu_par_ports.sv
module mcu_par_ports
  import mcu_map_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_portb,
  input  logic          we_portc,
  input  logic          we_ddrc,
  input  logic [PW-1:0] wdata,
  input  logic [PW-1:0] pins_in,
  output logic [PW-1:0] portb_q,
  output logic [PW-1:0] portc_q,
  output logic [PW-1:0] ddrc_q,
  output logic [PW-1:0] portc_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      portb_q <= '0;
      portc_q <= '0;
      ddrc_q  <= '0;
    end else begin
      if (we_portb) portb_q <= wdata;
      if (we_portc) portc_q <= wdata;
      if (we_ddrc)  ddrc_q  <= wdata;
    end
  end

  // Per-bit source select, one mux per pin.
  generate
    for (genvar i = 0; i < PW; i++) begin : g_pin
      assign portc_rd[i] = ddrc_q[i] ? portc_q[i] : pins_in[i];
    end
  endgenerate

  a_r4_portb_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_portb |=> portb_q == $past(wdata));
  a_r4_portb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_portb |=> $stable(portb_q));
  a_r5_ddrc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ddrc |=> $stable(ddrc_q));
  a_r6_portc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_portc |=> $stable(portc_q));
  a_r7_portc_mix: assert property (@(posedge clk) disable iff (!rst_n)
    portc_rd == portc_view(portc_q, pins_in, ddrc_q));

endmodule

// File: rtl/mcu_memmap.sv
module mcu_memmap
  import mcu_map_pkg::*;
#(
  parameter int         RAM_BYTES = 512,
  parameter int         ROM_BYTES = 12288,
  parameter logic [7:0] ROM_KEY   = 8'hA5,
  localparam int        RAM_IW    = $clog2(RAM_BYTES),
  localparam int        ROM_IW    = $clog2(ROM_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  input  logic        cpu_we,
  output logic [7:0]  cpu_rdata,
  output logic [7:0]  portb_out,
  input  logic [7:0]  portc_pin_in,
  output logic [7:0]  portc_out,
  output logic [7:0]  portc_oe
);
  region_e           region;
  logic              sel_ram, sel_rom, sel_portb, sel_portc, sel_ddrc;
  logic [RAM_IW-1:0] ram_idx;
  logic [ROM_IW-1:0] rom_off;
  logic [7:0]        ram_rd, rom_rd, portc_rd;
  logic              ram_we, portb_we, portc_we, ddrc_we;

  mcu_addr_decode #(
    .AW(16), .RAM_BASE(16'h0000), .RAM_BYTES(RAM_BYTES),
    .ROM_BASE(16'hD000), .ROM_BYTES(ROM_BYTES),
    .PORTB_ADDR(16'h1004), .PORTC_ADDR(16'h1003), .DDRC_ADDR(16'h1007)
  ) u_dec (
    .addr(cpu_addr), .region(region),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_portb(sel_portb),
    .sel_portc(sel_portc), .sel_ddrc(sel_ddrc),
    .ram_idx(ram_idx), .rom_off(rom_off)
  );

  assign ram_we   = cpu_we & sel_ram;
  assign portb_we = cpu_we & sel_portb;
  assign portc_we = cpu_we & sel_portc;
  assign ddrc_we  = cpu_we & sel_ddrc;

  mcu_ram #(.DEPTH(RAM_BYTES), .DW(8)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx),
    .wdata(cpu_wdata), .rdata(ram_rd)
  );

  mcu_rom #(.ROM_KEY(ROM_KEY), .OW(ROM_IW)) u_rom (
    .off(rom_off), .rdata(rom_rd)
  );

  mcu_par_ports #(.PW(8)) u_ports (
    .clk(clk), .rst_n(rst_n),
    .we_portb(portb_we), .we_portc(portc_we), .we_ddrc(ddrc_we),
    .wdata(cpu_wdata), .pins_in(portc_pin_in),
    .portb_q(portb_out), .portc_q(portc_out), .ddrc_q(portc_oe),
    .portc_rd(portc_rd)
  );

  always_comb begin
    unique case (region)
      RG_RAM:   cpu_rdata = ram_rd;
      RG_ROM:   cpu_rdata = rom_rd;
      RG_PORTB: cpu_rdata = portb_out;
      RG_PORTC: cpu_rdata = portc_rd;
      RG_DDRC:  cpu_rdata = portc_oe;
      default:  cpu_rdata = 8'h00;
    endcase
  end

  a_r8_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ram, sel_rom, sel_portb, sel_portc, sel_ddrc}));
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NONE) |-> (cpu_rdata == 8'h00));
  a_r7_portc_readback: assert property (@(posedge clk) disable iff (!rst_n)
    sel_portc |-> cpu_rdata == ((portc_out & portc_oe) | (portc_pin_in & ~portc_oe)));
  a_r9_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |=> $stable({portb_out, portc_out, portc_oe}));
  a_r3_rom_no_reg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && sel_rom) |=> $stable({portb_out, portc_out, portc_oe}));

endmodule

// File: tb/mcu_memmap_bench.sv
`timescale 1ns/1ps
module mcu_memmap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [7:0]  portb_out;
  logic [7:0]  portc_pin_in = '0;
  logic [7:0]  portc_out;
  logic [7:0]  portc_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference state, held behaviourally.
  int ram_m [int];
  int m_pb = 0, m_pc = 0, m_ddr = 0;

  always #2 clk = ~clk;

  mcu_memmap u_mcu_memmap (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .portb_out(portb_out),
    .portc_pin_in(portc_pin_in), .portc_out(portc_out), .portc_oe(portc_oe)
  );

  function automatic int rom_ref(int a);
    int o;
    o = a - 'hD000;
    return ((o % 256) ^ (((o / 256) * 3) % 256)) ^ 'hA5;
  endfunction

  // Returns -1 where the value is not predictable (unwritten RAM).
  function automatic int read_ref(int a, int pins);
    if (a < 512) return ram_m.exists(a) ? ram_m[a] : -1;
    if (a >= 'hD000) return rom_ref(a);
    if (a == 'h1004) return m_pb;
    if (a == 'h1007) return m_ddr;
    if (a == 'h1003) begin
      int r = 0;
      for (int i = 0; i < 8; i++)
        r |= (((m_ddr >> i) & 1) ? (m_pc & (1 << i)) : (pins & (1 << i)));
      return r;
    end
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive on the falling edge, compare, then commit to the model after the rising edge.
  task automatic op(int a, int wd, bit we, int pins, string tag);
    int e;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = 8'(wd); cpu_we = we; portc_pin_in = 8'(pins);
    #1;
    e = read_ref(a, pins);
    if (e >= 0) check({tag, " rdata"}, int'(cpu_rdata), e);
    check({tag, " R4 portb_out"}, int'(portb_out), m_pb);
    check({tag, " R6 portc_out"}, int'(portc_out), m_pc);
    check({tag, " R5 portc_oe"}, int'(portc_oe), m_ddr);
    @(posedge clk);
    #0.5;
    if (we) begin
      if (a < 512) ram_m[a] = wd & 255;
      else if (a == 'h1004) m_pb = wd & 255;
      else if (a == 'h1003) m_pc = wd & 255;
      else if (a == 'h1007) m_ddr = wd & 255;
    end
    cpu_we = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R4 reset portb", int'(portb_out), 0);
    check("R6 reset portc latch", int'(portc_out), 0);
    check("R5 reset ddrc", int'(portc_oe), 0);
    @(negedge clk); rst_n = 1'b1;

    // R5 reset value readable; R7 all inputs after reset
    op('h1007, 0, 0, 'h5A, "R5 ddrc read");
    op('h1003, 0, 0, 'h5A, "R7 pins only");
    // R1 RAM edges and middle
    op('h0000, 'h11, 1, 0, "R1 wr 0000");
    op('h01FF, 'hEE, 1, 0, "R1 wr 01FF");
    op('h0100, 'h77, 1, 0, "R1 wr 0100");
    op('h0000, 0, 0, 0, "R1 rd 0000");
    op('h01FF, 0, 0, 0, "R1 rd 01FF");
    op('h0100, 0, 0, 0, "R1 rd 0100");
    // R2 no aliasing above RAM
    op('h0200, 'h99, 1, 0, "R2 wr 0200");
    op('h0200, 0, 0, 0, "R2 rd 0200");
    op('h0000, 0, 0, 0, "R2 0000 intact");
    op('h0400, 'h98, 1, 0, "R2 wr 0400");
    op('h0000, 0, 0, 0, "R2 0000 intact2");
    // R3 ROM
    op('hD000, 0, 0, 0, "R3 rom D000");
    op('hD0FF, 0, 0, 0, "R3 rom D0FF");
    op('hE123, 0, 0, 0, "R3 rom E123");
    op('hFFFF, 'h00, 1, 0, "R3 wr FFFF");
    op('hFFFF, 0, 0, 0, "R3 rom FFFF");
    // R4 output port
    op('h1004, 'hC3, 1, 0, "R4 wr portb");
    op('h1004, 0, 0, 0, "R4 rd portb");
    // R9 strobe low
    op('h1004, 'h3C, 0, 0, "R9 no strobe portb");
    op('h0000, 'h55, 0, 0, "R9 no strobe ram");
    op('h0000, 0, 0, 0, "R9 ram intact");
    // R6/R7 bidirectional port
    op('h1003, 'h3C, 1, 'hA5, "R6 wr latch");
    op('h1003, 0, 0, 'hA5, "R7 ddr=00");
    op('h1007, 'h0F, 1, 'hA5, "R5 wr ddr");
    op('h1003, 0, 0, 'hA5, "R7 ddr=0F");
    op('h1003, 0, 0, 'h5A, "R7 pins moved");
    op('h1007, 'hFF, 1, 'h00, "R5 ddr=FF");
    op('h1003, 0, 0, 'hFF, "R7 ddr=FF");
    // R8 unmapped
    op('h1000, 'hFF, 1, 0, "R8 1000");
    op('h1005, 'hFF, 1, 0, "R8 1005");
    op('h1006, 'hFF, 1, 0, "R8 1006");
    op('h1008, 'hFF, 1, 0, "R8 1008");
    op('hCFFF, 'hFF, 1, 0, "R8 CFFF");
    op('h1000, 0, 0, 0, "R8 rd 1000");
    op('hCFFF, 0, 0, 0, "R8 rd CFFF");

    // Mixed traffic across every region
    for (int n = 0; n < 400; n++) begin
      int pick, a;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: a = $urandom_range(0, 511);
        3:       a = $urandom_range('hD000, 'hFFFF);
        4:       a = 'h1004;
        5:       a = 'h1003;
        6:       a = 'h1007;
        7:       a = $urandom_range('h0200, 'hCFFF);
        default: a = $urandom_range(0, 'h01FF);
      endcase
      op(a, $urandom_range(0, 255), 1'($urandom_range(0, 1)),
         $urandom_range(0, 255), "R1 R3 R7 R8 mixed");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule